// File: doc/BRIEF.md
# Logic Analyzer Serial Command Decoder

This block is the device-side command front end of a logic analyzer that a host drives over a byte-wide serial link. The link runs at 115200 baud, 8 data bits, no parity and 1 stop bit. The UART serializer sits outside the block. It hands received bytes to the block one at a time through a valid strobe. The block splits the byte stream into commands. An opcode with bit 7 clear stands alone. An opcode with bit 7 set is followed by exactly four argument bytes, which form a 32-bit value with the least significant byte first.

Decoded commands leave the block as single-cycle strobes. Reset (0x00) and run (0x01) each have their own pulse. Every completed long command produces one register-write pulse that carries the opcode and the assembled argument, for the trigger, divider, size and flag logic downstream. Identify (0x02) and metadata (0x04) start a reply, which the block streams byte by byte to the UART transmitter. The block presents a reply byte only while the transmitter says it is ready. If a new command arrives, the current reply is cut short.

The metadata reply is a list of entries, each opened by a key byte, and a key of zero closes the list. In a key byte, bits 7:5 give the value type and bits 4:0 give the token. Because the host sends five reset bytes in a row, framing always recovers: at most four of them can be taken as arguments of a long command that was left unfinished.

Top module: `la_cmd_front`

## Requirements
- R1: A received byte with bit 7 clear is a complete short command. It is decoded on its own, and no command event of any kind occurs before the following byte.
- R2: A received byte with bit 7 set opens a long command. After the fourth following byte, reg_wr pulses for one cycle with reg_addr equal to the opcode and reg_data equal to the four argument bytes, the first received byte in bits 7:0 and the last in bits 31:24. Argument bytes are never decoded as opcodes.
- R3: Five consecutive 0x00 bytes leave the block waiting for an opcode, whatever it was doing before. If k argument bytes (0 to 3) of a long command had already arrived, exactly k+1 reset pulses follow.
- R4: A short opcode 0x00 pulses reset_pulse for one cycle. A short opcode 0x01 pulses run_pulse for one cycle.
- R5: A short opcode 0x02 sends exactly four bytes: 0x31, 0x53, 0x4C, 0x4F.
- R6: A short opcode 0x04 sends a 32-byte metadata stream, in this order:
  - key 0x01 with the name string "LAC1" and a 0x00 terminator;
  - key 0x02 with the version string "2.1" and a 0x00 terminator;
  - key 0x20 with the probe count;
  - key 0x21 with the memory size in bytes;
  - key 0x23 with the maximum sample rate in Hz;
  - key 0x24 with the protocol version;
  - a closing key 0x00.
- R7: Each 32-bit metadata value (type 1) follows its key as four bytes, most significant first. With the default parameters these are 32, 24576, 200000000 and 2.
- R8: tx_valid is high only while tx_ready is high. Each cycle with tx_valid high sends one byte, and the reply does not advance while tx_ready is low.
- R9: A command that completes while a reply is pending ends the reply. If that command is identify or metadata, its own reply starts from its first byte instead.
- R10: Short opcodes other than 0x00, 0x01, 0x02 and 0x04 produce no pulse, no register write and no reply byte.
- R11: After reset, tx_valid, reg_wr, reset_pulse and run_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a byte this cycle |
| tx_valid | output | 1 | Reply byte offered and taken this cycle |
| tx_byte | output | 8 | Reply byte |
| reset_pulse | output | 1 | One-cycle reset command strobe |
| run_pulse | output | 1 | One-cycle run command strobe |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Opcode of the long command |
| reg_data | output | 32 | Assembled argument, first byte lowest |

## Verification
The assertions assume that the receiver delivers at most one byte per cycle as a single-cycle rx_valid, and that the transmitter takes a byte in every cycle where both tx_valid and tx_ready are high. The bench keeps to both. It drives each byte for exactly one cycle with idle cycles between bytes. It changes tx_ready only shortly after a rising edge, either holding it steady or following a pseudo-random pattern. The sweeps cover every short opcode, long commands whose arguments contain opcode values, every partial-argument depth before a resynchronizing reset run, and aborted or restarted replies.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;

    localparam int BYTE_W    = 8;
    localparam int ARG_BYTES = 4;
    localparam int ARG_W     = BYTE_W * ARG_BYTES;

    localparam logic [7:0] OPC_RESET = 8'h00;
    localparam logic [7:0] OPC_RUN   = 8'h01;
    localparam logic [7:0] OPC_IDENT = 8'h02;
    localparam logic [7:0] OPC_META  = 8'h04;

    localparam int ID_LEN   = 4;
    localparam int META_LEN = 32;
    localparam int IDX_W    = $clog2(META_LEN);

    typedef enum logic [1:0] {
        RPL_NONE,
        RPL_IDENT,
        RPL_META
    } reply_kind_e;

    typedef struct packed {
        logic             valid;
        logic [BYTE_W-1:0] opcode;
    } short_evt_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] addr;
        logic [ARG_W-1:0]  data;
    } reg_wr_t;

    function automatic logic is_long(input logic [7:0] op);
        return op[7];
    endfunction

    function automatic logic [7:0] meta_key(input logic [2:0] kind, input logic [4:0] token);
        return {kind, token};
    endfunction

    // pos 0 selects the most significant byte
    function automatic logic [7:0] be_byte(input logic [31:0] w, input logic [1:0] pos);
        return w[8*(3-int'(pos)) +: 8];
    endfunction

    function automatic logic [7:0] ident_byte(input logic [1:0] pos);
        case (pos)
            2'd0:    return 8'h31;
            2'd1:    return 8'h53;
            2'd2:    return 8'h4C;
            default: return 8'h4F;
        endcase
    endfunction

endpackage

// File: rtl/la_cmd_framer.sv
module la_cmd_framer
    import la_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output short_evt_t short_o,
    output reg_wr_t    wr_o
);
    localparam int CNT_W = $clog2(ARG_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ARG_BYTES - 1);

    typedef enum logic {FR_OP, FR_ARG} fr_state_e;

    fr_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [7:0]         op_q;
    logic [ARG_W-1:0]   arg_q;
    logic [ARG_W-1:0]   arg_next;

    always_comb begin
        arg_next = arg_q;
        arg_next[int'(cnt)*8 +: 8] = rx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FR_OP;
            cnt     <= '0;
            op_q    <= '0;
            arg_q   <= '0;
            short_o <= '0;
            wr_o    <= '0;
        end else begin
            short_o.valid <= 1'b0;
            wr_o.valid    <= 1'b0;
            if (rx_valid) begin
                case (state)
                    FR_OP: begin
                        if (is_long(rx_byte)) begin
                            op_q  <= rx_byte;
                            cnt   <= '0;
                            arg_q <= '0;
                            state <= FR_ARG;
                        end else begin
                            short_o <= '{valid: 1'b1, opcode: rx_byte};
                        end
                    end
                    default: begin
                        arg_q <= arg_next;
                        if (cnt == CNT_LAST) begin
                            wr_o  <= '{valid: 1'b1, addr: op_q, data: arg_next};
                            state <= FR_OP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // run of consecutive zero bytes, saturating, used by the resync check
    logic [2:0] zrun;
    always_ff @(posedge clk) begin
        if (rst) zrun <= '0;
        else if (rx_valid) zrun <= (rx_byte != 8'h00) ? 3'd0 : ((zrun == 3'd5) ? 3'd5 : zrun + 3'd1);
    end

    assert_resync_R3: assert property (@(posedge clk) disable iff (rst)
        (zrun == 3'd5) |-> (state == FR_OP));

    assert_one_event_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({short_o.valid, wr_o.valid}));

    assert_long_opcode_R2: assert property (@(posedge clk) disable iff (rst)
        wr_o.valid |-> wr_o.addr[7]);

endmodule

// File: rtl/la_reply_rom.sv
module la_reply_rom
    import la_cmd_pkg::*;
#(
    parameter logic [31:0] PROBES    = 32'd32,
    parameter logic [31:0] MEM_BYTES = 32'd24576,
    parameter logic [31:0] MAX_RATE  = 32'd200000000,
    parameter logic [31:0] PROTO_VER = 32'd2,
    parameter logic [31:0] DEV_NAME  = 32'h4C414331,
    parameter logic [23:0] FW_VER    = 24'h322E31
)(
    input  reply_kind_e      kind,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);
    // layout: name entry 0..5, version entry 6..10, four numeric entries of
    // five bytes from 11, closing key at 31
    localparam int NUM_BASE = 11;
    localparam int NUM_STEP = 1 + ARG_BYTES;

    int          pos;
    int          grp;
    int          off;
    logic [4:0]  tok;
    logic [31:0] val;

    always_comb begin
        pos = int'(idx);
        grp = (pos - NUM_BASE) / NUM_STEP;
        off = (pos - NUM_BASE) % NUM_STEP;
        case (grp)
            0:       begin tok = 5'h00; val = PROBES;    end
            1:       begin tok = 5'h01; val = MEM_BYTES; end
            2:       begin tok = 5'h03; val = MAX_RATE;  end
            default: begin tok = 5'h04; val = PROTO_VER; end
        endcase

        byte_o = 8'h00;
        if (kind == RPL_IDENT) begin
            byte_o = ident_byte(idx[1:0]);
        end else if (kind == RPL_META) begin
            if (pos == 0)
                byte_o = meta_key(3'd0, 5'h01);
            else if (pos <= 4)
                byte_o = DEV_NAME[8*(4-pos) +: 8];
            else if (pos == 6)
                byte_o = meta_key(3'd0, 5'h02);
            else if (pos >= 7 && pos <= 9)
                byte_o = FW_VER[8*(9-pos) +: 8];
            else if (pos >= NUM_BASE && pos < NUM_BASE + 4*NUM_STEP) begin
                if (off == 0)
                    byte_o = meta_key(3'd1, tok);
                else
                    byte_o = be_byte(val, 2'(off - 1));
            end
        end
    end

endmodule

// File: rtl/la_reply_sender.sv
module la_reply_sender
    import la_cmd_pkg::*;
#(
    parameter logic [31:0] PROBES    = 32'd32,
    parameter logic [31:0] MEM_BYTES = 32'd24576,
    parameter logic [31:0] MAX_RATE  = 32'd200000000,
    parameter logic [31:0] PROTO_VER = 32'd2,
    parameter logic [31:0] DEV_NAME  = 32'h4C414331,
    parameter logic [23:0] FW_VER    = 24'h322E31
)(
    input  logic       clk,
    input  logic       rst,
    input  short_evt_t short_i,
    input  reg_wr_t    wr_i,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    localparam logic [IDX_W-1:0] ID_LAST   = IDX_W'(ID_LEN - 1);
    localparam logic [IDX_W-1:0] META_LAST = IDX_W'(META_LEN - 1);

    reply_kind_e      kind;
    logic             busy;
    logic [IDX_W-1:0] idx;
    logic             evt;
    logic             start_id;
    logic             start_meta;
    logic [IDX_W-1:0] last_idx;

    assign evt        = short_i.valid | wr_i.valid;
    assign start_id   = short_i.valid && (short_i.opcode == OPC_IDENT);
    assign start_meta = short_i.valid && (short_i.opcode == OPC_META);
    assign last_idx   = (kind == RPL_IDENT) ? ID_LAST : META_LAST;
    assign tx_valid   = busy && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            kind <= RPL_NONE;
            idx  <= '0;
        end else if (start_id || start_meta) begin
            busy <= 1'b1;
            kind <= start_id ? RPL_IDENT : RPL_META;
            idx  <= '0;
        end else if (evt) begin
            busy <= 1'b0;
            kind <= RPL_NONE;
            idx  <= '0;
        end else if (tx_valid) begin
            if (idx == last_idx) begin
                busy <= 1'b0;
                kind <= RPL_NONE;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    la_reply_rom #(
        .PROBES(PROBES), .MEM_BYTES(MEM_BYTES), .MAX_RATE(MAX_RATE),
        .PROTO_VER(PROTO_VER), .DEV_NAME(DEV_NAME), .FW_VER(FW_VER)
    ) u_rom (
        .kind  (kind),
        .idx   (idx),
        .byte_o(tx_byte)
    );

    assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !tx_ready && !evt) |=> (busy && $stable(idx)));

    assert_abort_on_command_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && evt && !start_id && !start_meta) |=> !busy);

    assert_closing_key_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && kind == RPL_META && idx == META_LAST) |-> (tx_byte == 8'h00));

endmodule

// File: rtl/la_cmd_front.sv
module la_cmd_front
    import la_cmd_pkg::*;
#(
    parameter logic [31:0] PROBES    = 32'd32,
    parameter logic [31:0] MEM_BYTES = 32'd24576,
    parameter logic [31:0] MAX_RATE  = 32'd200000000,
    parameter logic [31:0] PROTO_VER = 32'd2,
    parameter logic [31:0] DEV_NAME  = 32'h4C414331,
    parameter logic [23:0] FW_VER    = 24'h322E31
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        reset_pulse,
    output logic        run_pulse,
    output logic        reg_wr,
    output logic [7:0]  reg_addr,
    output logic [31:0] reg_data
);
    short_evt_t short_evt;
    reg_wr_t    wr_evt;

    la_cmd_framer u_framer (
        .clk     (clk),
        .rst     (rst),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .short_o (short_evt),
        .wr_o    (wr_evt)
    );

    la_reply_sender #(
        .PROBES(PROBES), .MEM_BYTES(MEM_BYTES), .MAX_RATE(MAX_RATE),
        .PROTO_VER(PROTO_VER), .DEV_NAME(DEV_NAME), .FW_VER(FW_VER)
    ) u_sender (
        .clk     (clk),
        .rst     (rst),
        .short_i (short_evt),
        .wr_i    (wr_evt),
        .tx_ready(tx_ready),
        .tx_valid(tx_valid),
        .tx_byte (tx_byte)
    );

    assign reset_pulse = short_evt.valid && (short_evt.opcode == OPC_RESET);
    assign run_pulse   = short_evt.valid && (short_evt.opcode == OPC_RUN);
    assign reg_wr      = wr_evt.valid;
    assign reg_addr    = wr_evt.addr;
    assign reg_data    = wr_evt.data;

    assert_exclusive_strobes_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reset_pulse, run_pulse, reg_wr}));

    assert_pulse_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (run_pulse && !rx_valid) |=> !run_pulse);

endmodule

// File: tb/la_cmd_front_bench.sv
module la_cmd_front_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_ready = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        reset_pulse;
    logic        run_pulse;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_data;

    always #5 clk = ~clk;

    la_cmd_front #(
        .PROBES(32'd32), .MEM_BYTES(32'd24576), .MAX_RATE(32'd200000000),
        .PROTO_VER(32'd2), .DEV_NAME(32'h4C414331), .FW_VER(24'h322E31)
    ) u_la_cmd_front (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .reset_pulse(reset_pulse), .run_pulse(run_pulse),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // tx_ready control: 0 low, 1 high, 2 pseudo-random
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = (ready_mode == 1) ? 1'b1 : (ready_mode == 2) ? lfsr[0] : 1'b0;
    end

    // observation counters
    logic [7:0]  log_q [0:63];
    int          nlog = 0;
    int          n_run = 0;
    int          n_rst = 0;
    int          n_wr = 0;
    logic [7:0]  last_addr;
    logic [31:0] last_data;
    int          n_bad_valid = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_valid) begin
                if (nlog < 64) log_q[nlog] = tx_byte;
                nlog++;
                if (!tx_ready) n_bad_valid++;
            end
            if (run_pulse) n_run++;
            if (reset_pulse) n_rst++;
            if (reg_wr) begin
                n_wr++;
                last_addr = reg_addr;
                last_data = reg_data;
            end
        end
    end

    // expected metadata, built from the requirement text
    logic [7:0] exp_meta [0:31];
    int         nexp = 0;
    task automatic push(input logic [7:0] b);
        exp_meta[nexp] = b;
        nexp++;
    endtask
    task automatic push_word(input logic [7:0] key, input logic [31:0] w);
        push(key);
        for (int s = 24; s >= 0; s -= 8) push(8'((w >> s) & 32'hFF));
    endtask

    logic [7:0] exp_id [0:3];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        nlog = 0; n_run = 0; n_rst = 0; n_wr = 0; n_bad_valid = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
    endtask

    task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
        send_byte(op);
        for (int b = 0; b < 4; b++) send_byte(8'((arg >> (8*b)) & 32'hFF));
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic int cmp_log_meta();
        for (int i = 0; i < 32; i++) if (log_q[i] != exp_meta[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        push(8'h01); push(8'h4C); push(8'h41); push(8'h43); push(8'h31); push(8'h00);
        push(8'h02); push(8'h32); push(8'h2E); push(8'h31); push(8'h00);
        push_word(8'h20, 32'd32);
        push_word(8'h21, 32'd24576);
        push_word(8'h23, 32'd200000000);
        push_word(8'h24, 32'd2);
        push(8'h00);
        exp_id[0] = 8'h31; exp_id[1] = 8'h53; exp_id[2] = 8'h4C; exp_id[3] = 8'h4F;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(tx_valid == 0 && reg_wr == 0 && reset_pulse == 0 && run_pulse == 0,
              "R11 reset state", {tx_valid, reg_wr, reset_pulse, run_pulse}, 0);

        // sweep of every short opcode with the transmitter always ready
        ready_mode = 1;
        for (int op = 0; op < 128; op++) begin
            int exp_len;
            int bad;
            clear_obs();
            send_byte(8'(op));
            wait_cycles(40);
            exp_len = (op == 2) ? 4 : (op == 4) ? 32 : 0;
            if (op == 0)
                check(n_rst == 1 && n_run == 0, "R4 reset opcode", n_rst, 1);
            else if (op == 1)
                check(n_run == 1 && n_rst == 0, "R4 run opcode", n_run, 1);
            else if (op != 2 && op != 4)
                check(n_run == 0 && n_rst == 0 && n_wr == 0 && nlog == 0,
                      "R10 unused opcode inert", n_run + n_rst + n_wr + nlog, 0);
            check(n_wr == 0, "R1 short opcode makes no write", n_wr, 0);
            check(nlog == exp_len, "R5/R6 reply length", nlog, exp_len);
            if (op == 2 && nlog == 4) begin
                bad = -1;
                for (int i = 3; i >= 0; i--) if (log_q[i] != exp_id[i]) bad = i;
                check(bad < 0, "R5 identify bytes", (bad < 0) ? 0 : log_q[bad], (bad < 0) ? 0 : exp_id[bad]);
            end
            if (op == 4 && nlog == 32) begin
                bad = cmp_log_meta();
                check(bad < 0, "R6 metadata stream", (bad < 0) ? 0 : log_q[bad], (bad < 0) ? 0 : exp_meta[bad]);
                check({log_q[22], log_q[23], log_q[24], log_q[25]} == 32'd200000000,
                      "R7 rate most significant first",
                      {log_q[22], log_q[23], log_q[24], log_q[25]}, 32'd200000000);
                check(log_q[31] == 8'h00, "R6 closing key", log_q[31], 0);
            end
        end

        // long commands, arguments holding opcode values
        for (int n = 0; n < 8; n++) begin
            logic [7:0]  op;
            logic [31:0] arg;
            op  = 8'h80 | 8'((n * 37) & 8'h7F);
            arg = (32'h04020100 + 32'h11111111 * n) ^ (n[0] ? 32'h00040002 : 32'h0);
            clear_obs();
            send_long(op, arg);
            wait_cycles(40);
            check(n_wr == 1, "R2 one write per long command", n_wr, 1);
            check(last_addr == op, "R2 write address", last_addr, op);
            check(last_data == arg, "R2 data first byte lowest", last_data, arg);
            check(nlog == 0 && n_run == 0 && n_rst == 0, "R2 arguments not decoded",
                  nlog + n_run + n_rst, 0);
        end

        // resynchronisation after k partial argument bytes
        for (int k = 0; k < 4; k++) begin
            clear_obs();
            send_byte(8'hC3);
            for (int j = 0; j < k; j++) send_byte(8'(8'h10 + j));
            repeat (5) send_byte(8'h00);
            send_byte(8'h01);
            wait_cycles(5);
            check(n_rst == k + 1, "R3 reset pulses after resync", n_rst, k + 1);
            check(n_run == 1, "R3 opcode after resync", n_run, 1);
            check(n_wr == 1, "R3 unfinished command closed", n_wr, 1);
        end

        // stalled transmitter
        ready_mode = 0;
        clear_obs();
        send_byte(8'h02);
        wait_cycles(20);
        check(nlog == 0, "R8 no byte while not ready", nlog, 0);
        ready_mode = 1;
        wait_cycles(20);
        check(nlog == 4 && log_q[0] == 8'h31, "R8 reply resumes", nlog, 4);

        // random backpressure on the metadata reply
        ready_mode = 2;
        clear_obs();
        send_byte(8'h04);
        wait_cycles(300);
        check(nlog == 32, "R8 metadata length under backpressure", nlog, 32);
        if (nlog == 32) begin
            int bad;
            bad = cmp_log_meta();
            check(bad < 0, "R8 metadata bytes under backpressure",
                  (bad < 0) ? 0 : log_q[bad], (bad < 0) ? 0 : exp_meta[bad]);
        end
        check(n_bad_valid == 0, "R8 valid only with ready", n_bad_valid, 0);

        // abort by a new command
        ready_mode = 0;
        wait_cycles(2);
        clear_obs();
        send_byte(8'h04);
        send_byte(8'h01);
        ready_mode = 1;
        wait_cycles(50);
        check(nlog == 0, "R9 reply aborted by run", nlog, 0);

        ready_mode = 0;
        wait_cycles(2);
        clear_obs();
        send_byte(8'h04);
        send_long(8'h85, 32'hDEADBEEF);
        ready_mode = 1;
        wait_cycles(50);
        check(nlog == 0, "R9 reply aborted by register write", nlog, 0);

        ready_mode = 0;
        wait_cycles(2);
        clear_obs();
        send_byte(8'h04);
        send_byte(8'h02);
        ready_mode = 1;
        wait_cycles(50);
        check(nlog == 4 && log_q[0] == 8'h31 && log_q[3] == 8'h4F,
              "R9 identify restarts reply", nlog, 4);

        finish_run();
    end

endmodule